// File: doc/BRIEF.md
# Camera Link Bring-Up Sequencer

This block replaces a software bring-up routine for a serial camera receiver with a hardware state machine. A client pulses `start_i` or `stop_i`; the sequencer keeps a stream reference count and only runs the full power-up or power-down sequence on the first start and the last stop. Other requests just move the count.

A full start turns on the pixel clock. It then looks up a PHY frequency-range code from the per-lane bit rate and sends that code to the PHY through a write port with an acknowledge. Next it programs the lane-count field and releases the three reset lines in a fixed order. It then passes two timed status gates: first all active lanes must show stop state, and after the sensor stream request is raised the clock lane must show high-speed activity. Which rollback steps run after a failure depends on the step that failed. Each request ends with a one-cycle `done_o` and a failure code.

Top module: `cam_link_seq`

## Requirements
- R1: After reset the pixel-clock enable, all three active-low reset lines, the sensor request, the PHY write strobe, busy and done are low, and the stream count is 0.
- R2: A start request with `src_ok_i` or `sink_ok_i` low completes with fail code 1. No output other than done and the code changes, and the count is kept.
- R3: A start request whose lane count is 0 or above NLANES completes with fail code 2. The pixel clock is not enabled.
- R4: The range code is the one from the first table entry whose limit is strictly above the rate (e.g. 89→0x00, 90→0x20, 300→0x48, 849→0x14, 850→0x34, 999→0x74). When `rate_valid_i` is low, 849 is used. A rate of 1000 or more makes the pixel clock pulse on and off, no write or reset release happens, and the request completes with fail code 3.
- R5: A full start raises the pixel clock, sends the range code to PHY address RANGE_ADDR, sets the lane field to lanes−1, and then releases PHY shutdown, PHY reset and controller reset on three consecutive cycles.
- R6: The stop-state gate passes only when the clock-lane stop input and the stop input of every active lane (bits 0 to lanes−1) are high together. Stop inputs of inactive lanes are ignored.
- R7: The sensor request rises one cycle after controller reset release, once the stop gate has passed. A start succeeds only when the high-speed clock input is seen.
- R8: Each status gate gives up after TIMEOUT_CYC cycles. A stop-state timeout gives fail code 4 and a clock-activity timeout gives fail code 5.
- R9: After a clock-activity timeout, the sensor request drops first, all three resets assert on the next cycle, and the pixel clock is gated on the cycle after that.
- R10: After a stop-state timeout, the sensor request is never raised, the resets assert, and the pixel clock is gated one cycle later.
- R11: A start while the count is nonzero only adds one, with no PHY write and no change to the reset lines. A stop while the count is above one only subtracts one.
- R12: A stop at count one drops the sensor request, then asserts the resets, then gates the pixel clock, and leaves the count at 0. A stop at count 0 completes with fail code 0 and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Stream start request pulse |
| stop_i | input | 1 | Stream stop request pulse |
| src_ok_i | input | 1 | Upstream source attached |
| sink_ok_i | input | 1 | Downstream consumer attached |
| lanes_i | input | $clog2(NLANES+1) | Number of active data lanes |
| rate_valid_i | input | 1 | Rate input is supplied |
| rate_mbps_i | input | 11 | Per-lane bit rate in Mbps |
| phy_wr_ack_i | input | 1 | PHY accepted the range write |
| lane_stop_i | input | NLANES | Per-lane stop-state status |
| clk_stop_i | input | 1 | Clock-lane stop-state status |
| clk_hs_i | input | 1 | Clock-lane high-speed activity |
| pix_clk_en_o | output | 1 | Pixel clock enable |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| lane_cfg_o | output | max(1,$clog2(NLANES)) | Lane-count field, lanes minus one |
| sensor_run_o | output | 1 | Sensor stream request |
| phy_wr_valid_o | output | 1 | PHY range write strobe, held until ack |
| phy_wr_addr_o | output | 8 | PHY write address |
| phy_wr_data_o | output | 8 | PHY range code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Request complete, one cycle |
| fail_code_o | output | 3 | Result code of the last request |
| stream_cnt_o | output | CNT_W | Stream reference count |

## Verification
The bench builds the sequencer with NLANES=4 and TIMEOUT_CYC=40. With a 40-cycle timeout both status gates can be made to expire, and the exact rollback spacing after each kind of expiry can be checked in a few hundred cycles. Four lanes allow partial lane masks and show that stop inputs above the active lane count have no effect.

// File: rtl/cam_link_pkg.sv
package cam_link_pkg;

    localparam int RATE_W = 11;
    localparam logic [RATE_W-1:0] RATE_FALLBACK = 11'd849;

    typedef enum logic [2:0] {
        FAIL_NONE    = 3'd0,
        FAIL_NO_PATH = 3'd1,
        FAIL_LANES   = 3'd2,
        FAIL_RATE    = 3'd3,
        FAIL_STOP_TO = 3'd4,
        FAIL_CLK_TO  = 3'd5
    } fail_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RATE,
        ST_PHY_WR,
        ST_LANES,
        ST_REL_SD,
        ST_REL_PR,
        ST_REL_CR,
        ST_WAIT_STOP,
        ST_WAIT_CLK,
        ST_DROP_RUN,
        ST_HOLD_RST,
        ST_GATE_PIX
    } seq_e;

    // Returns {in_range, code}; first band whose upper limit exceeds the rate.
    function automatic logic [8:0] band_code(input logic [RATE_W-1:0] r);
        logic [7:0] c;
        logic       v;
        v = 1'b1;
        if      (r < 11'd90)   c = 8'h00;
        else if (r < 11'd100)  c = 8'h20;
        else if (r < 11'd110)  c = 8'h40;
        else if (r < 11'd125)  c = 8'h02;
        else if (r < 11'd140)  c = 8'h22;
        else if (r < 11'd150)  c = 8'h42;
        else if (r < 11'd160)  c = 8'h04;
        else if (r < 11'd180)  c = 8'h24;
        else if (r < 11'd200)  c = 8'h44;
        else if (r < 11'd210)  c = 8'h06;
        else if (r < 11'd240)  c = 8'h26;
        else if (r < 11'd250)  c = 8'h46;
        else if (r < 11'd270)  c = 8'h08;
        else if (r < 11'd300)  c = 8'h28;
        else if (r < 11'd330)  c = 8'h48;
        else if (r < 11'd360)  c = 8'h2a;
        else if (r < 11'd400)  c = 8'h4a;
        else if (r < 11'd450)  c = 8'h0c;
        else if (r < 11'd500)  c = 8'h2c;
        else if (r < 11'd550)  c = 8'h0e;
        else if (r < 11'd600)  c = 8'h2e;
        else if (r < 11'd650)  c = 8'h10;
        else if (r < 11'd700)  c = 8'h30;
        else if (r < 11'd750)  c = 8'h12;
        else if (r < 11'd800)  c = 8'h32;
        else if (r < 11'd850)  c = 8'h14;
        else if (r < 11'd900)  c = 8'h34;
        else if (r < 11'd950)  c = 8'h54;
        else if (r < 11'd1000) c = 8'h74;
        else begin
            c = 8'h00;
            v = 1'b0;
        end
        return {v, c};
    endfunction

endpackage

// File: rtl/cam_rate_lut.sv
module cam_rate_lut
    import cam_link_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    output logic              ok_o,
    output logic [7:0]        code_o
);
    logic [8:0] sel;

    always_comb begin
        sel    = band_code(rate_i);
        ok_o   = sel[8];
        code_o = sel[7:0];
    end
endmodule

// File: rtl/cam_poll_timer.sv
module cam_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == TW'(LIMIT - 1));
        cnt_d     = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (run_i && !expired_o)
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_timer_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TW'(LIMIT))
        else $error("poll timer passed its limit");
endmodule

// File: rtl/cam_stop_mask.sv
module cam_stop_mask #(
    parameter int NLANES = 4
) (
    input  logic [$clog2(NLANES+1)-1:0] lanes_i,
    input  logic [NLANES-1:0]           lane_stop_i,
    input  logic                        clk_stop_i,
    output logic                        met_o
);
    localparam int LN_W = $clog2(NLANES + 1);

    logic [NLANES-1:0] lane_ok;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign lane_ok[i] = lane_stop_i[i] || (LN_W'(i) >= lanes_i);
    end

    assign met_o = clk_stop_i && (&lane_ok);
endmodule

// File: rtl/cam_link_seq.sv
module cam_link_seq
    import cam_link_pkg::*;
#(
    parameter int         NLANES      = 4,
    parameter int         TIMEOUT_CYC = 125000000,
    parameter int         CNT_W       = 4,
    parameter logic [7:0] RANGE_ADDR  = 8'h44
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic                                 stop_i,
    input  logic                                 src_ok_i,
    input  logic                                 sink_ok_i,
    input  logic [$clog2(NLANES+1)-1:0]          lanes_i,
    input  logic                                 rate_valid_i,
    input  logic [10:0]                          rate_mbps_i,
    input  logic                                 phy_wr_ack_i,
    input  logic [NLANES-1:0]                    lane_stop_i,
    input  logic                                 clk_stop_i,
    input  logic                                 clk_hs_i,
    output logic                                 pix_clk_en_o,
    output logic                                 phy_shutdown_n_o,
    output logic                                 phy_rst_n_o,
    output logic                                 ctrl_rst_n_o,
    output logic [((NLANES>1)?$clog2(NLANES):1)-1:0] lane_cfg_o,
    output logic                                 sensor_run_o,
    output logic                                 phy_wr_valid_o,
    output logic [7:0]                           phy_wr_addr_o,
    output logic [7:0]                           phy_wr_data_o,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic [2:0]                           fail_code_o,
    output logic [CNT_W-1:0]                     stream_cnt_o
);
    localparam int LN_W = $clog2(NLANES + 1);
    localparam int LC_W = (NLANES > 1) ? $clog2(NLANES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        seq_e               st;
        fail_e              code;
        logic               done;
        logic               busy;
        logic               pix;
        logic               sd_n;
        logic               pr_n;
        logic               cr_n;
        logic               run;
        logic [LC_W-1:0]    lane_cfg;
        logic               wr_v;
        logic [7:0]         wr_d;
        logic [LN_W-1:0]    lanes;
        logic [RATE_W-1:0]  rate;
        logic [CNT_W-1:0]   cnt;
        logic               tearing;
    } seq_t;

    seq_t q, d;

    logic       lut_ok;
    logic [7:0] lut_code;
    logic       stop_met;
    logic       tmr_run, tmr_clear, tmr_expired;

    cam_rate_lut u_lut (
        .rate_i (q.rate),
        .ok_o   (lut_ok),
        .code_o (lut_code)
    );

    cam_stop_mask #(.NLANES(NLANES)) u_mask (
        .lanes_i     (q.lanes),
        .lane_stop_i (lane_stop_i),
        .clk_stop_i  (clk_stop_i),
        .met_o       (stop_met)
    );

    assign tmr_run   = (q.st == ST_WAIT_STOP) || (q.st == ST_WAIT_CLK);
    assign tmr_clear = !tmr_run || ((q.st == ST_WAIT_STOP) && stop_met);

    cam_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.busy = 1'b0;
                if (start_i) begin
                    if (!src_ok_i || !sink_ok_i) begin
                        d.done = 1'b1;
                        d.code = FAIL_NO_PATH;
                    end else if (lanes_i == '0 || lanes_i > LN_W'(NLANES)) begin
                        d.done = 1'b1;
                        d.code = FAIL_LANES;
                    end else if (q.cnt != '0) begin
                        d.done = 1'b1;
                        d.code = FAIL_NONE;
                        if (q.cnt != CNT_MAX) d.cnt = q.cnt + CNT_W'(1);
                    end else begin
                        d.busy    = 1'b1;
                        d.pix     = 1'b1;
                        d.lanes   = lanes_i;
                        d.rate    = rate_valid_i ? rate_mbps_i : RATE_FALLBACK;
                        d.code    = FAIL_NONE;
                        d.tearing = 1'b0;
                        d.st      = ST_RATE;
                    end
                end else if (stop_i) begin
                    d.code = FAIL_NONE;
                    if (q.cnt == CNT_W'(1)) begin
                        d.busy    = 1'b1;
                        d.tearing = 1'b1;
                        d.st      = ST_DROP_RUN;
                    end else begin
                        d.done = 1'b1;
                        if (q.cnt != '0) d.cnt = q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_RATE: begin
                if (!lut_ok) begin
                    d.code = FAIL_RATE;
                    d.st   = ST_GATE_PIX;
                end else begin
                    d.wr_v = 1'b1;
                    d.wr_d = lut_code;
                    d.st   = ST_PHY_WR;
                end
            end
            ST_PHY_WR: begin
                if (phy_wr_ack_i) begin
                    d.wr_v = 1'b0;
                    d.st   = ST_LANES;
                end
            end
            ST_LANES: begin
                d.lane_cfg = LC_W'(q.lanes - LN_W'(1));
                d.st       = ST_REL_SD;
            end
            ST_REL_SD: begin
                d.sd_n = 1'b1;
                d.st   = ST_REL_PR;
            end
            ST_REL_PR: begin
                d.pr_n = 1'b1;
                d.st   = ST_REL_CR;
            end
            ST_REL_CR: begin
                d.cr_n = 1'b1;
                d.st   = ST_WAIT_STOP;
            end
            ST_WAIT_STOP: begin
                if (stop_met) begin
                    d.run = 1'b1;
                    d.st  = ST_WAIT_CLK;
                end else if (tmr_expired) begin
                    d.code = FAIL_STOP_TO;
                    d.st   = ST_HOLD_RST;
                end
            end
            ST_WAIT_CLK: begin
                if (clk_hs_i) begin
                    d.cnt  = CNT_W'(1);
                    d.done = 1'b1;
                    d.busy = 1'b0;
                    d.st   = ST_IDLE;
                end else if (tmr_expired) begin
                    d.code = FAIL_CLK_TO;
                    d.st   = ST_DROP_RUN;
                end
            end
            ST_DROP_RUN: begin
                d.run = 1'b0;
                d.st  = ST_HOLD_RST;
            end
            ST_HOLD_RST: begin
                d.sd_n = 1'b0;
                d.pr_n = 1'b0;
                d.cr_n = 1'b0;
                d.st   = ST_GATE_PIX;
            end
            ST_GATE_PIX: begin
                d.pix  = 1'b0;
                d.done = 1'b1;
                d.busy = 1'b0;
                if (q.tearing) d.cnt = '0;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_clk_en_o     = q.pix;
    assign phy_shutdown_n_o = q.sd_n;
    assign phy_rst_n_o      = q.pr_n;
    assign ctrl_rst_n_o     = q.cr_n;
    assign lane_cfg_o       = q.lane_cfg;
    assign sensor_run_o     = q.run;
    assign phy_wr_valid_o   = q.wr_v;
    assign phy_wr_addr_o    = RANGE_ADDR;
    assign phy_wr_data_o    = q.wr_d;
    assign busy_o           = q.busy;
    assign done_o           = q.done;
    assign fail_code_o      = q.code;
    assign stream_cnt_o     = q.cnt;

    p_run_needs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_run_o |-> (phy_shutdown_n_o && phy_rst_n_o && ctrl_rst_n_o))
        else $error("sensor request while a reset is asserted");

    p_release_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_n_o |-> (phy_rst_n_o && phy_shutdown_n_o))
        else $error("controller reset released out of order");

    p_pix_under_phy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_shutdown_n_o |-> pix_clk_en_o)
        else $error("PHY powered without pixel clock");

    p_run_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sensor_run_o) |-> $past(clk_stop_i))
        else $error("sensor request without clock-lane stop state");

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_cnt_o != $past(stream_cnt_o)) |->
            ((stream_cnt_o == $past(stream_cnt_o) + CNT_W'(1)) ||
             (stream_cnt_o == $past(stream_cnt_o) - CNT_W'(1))))
        else $error("stream count jumped");

    p_refuse_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_code_o == FAIL_NO_PATH) |-> $stable(stream_cnt_o))
        else $error("refused start changed the count");

    p_rate_fail_no_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_code_o == FAIL_RATE) |-> (!phy_shutdown_n_o && !pix_clk_en_o))
        else $error("rate failure left PHY or clock on");

    p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o)
        else $error("done while busy");
endmodule

// File: tb/tb_cam_link_seq.sv
`timescale 1ns/1ps
module tb_cam_link_seq;
    localparam int NL  = 4;
    localparam int TMO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic       src_ok = 1'b1, sink_ok = 1'b1;
    logic [2:0] lanes = 3'd2;
    logic       rate_valid = 1'b1;
    logic [10:0] rate = 11'd300;
    logic       phy_ack = 1'b0;
    logic [NL-1:0] lane_stop = '0;
    logic       clk_stop = 1'b0, clk_hs = 1'b0;

    logic       pix, sd_n, pr_n, cr_n, run, wr_v, busy, done;
    logic [1:0] lane_cfg;
    logic [7:0] wr_a, wr_d;
    logic [2:0] code;
    logic [3:0] cnt;

    always #2 clk = ~clk;

    cam_link_seq #(.NLANES(NL), .TIMEOUT_CYC(TMO), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .src_ok_i(src_ok), .sink_ok_i(sink_ok), .lanes_i(lanes),
        .rate_valid_i(rate_valid), .rate_mbps_i(rate), .phy_wr_ack_i(phy_ack),
        .lane_stop_i(lane_stop), .clk_stop_i(clk_stop), .clk_hs_i(clk_hs),
        .pix_clk_en_o(pix), .phy_shutdown_n_o(sd_n), .phy_rst_n_o(pr_n),
        .ctrl_rst_n_o(cr_n), .lane_cfg_o(lane_cfg), .sensor_run_o(run),
        .phy_wr_valid_o(wr_v), .phy_wr_addr_o(wr_a), .phy_wr_data_o(wr_d),
        .busy_o(busy), .done_o(done), .fail_code_o(code), .stream_cnt_o(cnt)
    );

    // PHY write responder: one-cycle acknowledge
    always @(posedge clk) phy_ack <= wr_v && !phy_ack;

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model state
    int  m_cnt = 0;
    bit  m_up  = 0;
    bit  in_op = 0;

    // event recorder
    int cyc = 0;
    int t_pix_r, t_pix_f, t_sd_r, t_pr_r, t_cr_r, t_cr_f, t_run_r, t_run_f, n_wr, wr_data, wr_addr;
    logic p_pix = 0, p_sd = 0, p_pr = 0, p_cr = 0, p_run = 0, p_wr = 0;

    task automatic clear_ev();
        t_pix_r = -1; t_pix_f = -1; t_sd_r = -1; t_pr_r = -1; t_cr_r = -1;
        t_cr_f = -1; t_run_r = -1; t_run_f = -1; n_wr = 0; wr_data = -1; wr_addr = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (pix && !p_pix) t_pix_r = cyc;
        if (!pix && p_pix) t_pix_f = cyc;
        if (sd_n && !p_sd) t_sd_r = cyc;
        if (pr_n && !p_pr) t_pr_r = cyc;
        if (cr_n && !p_cr) t_cr_r = cyc;
        if (!cr_n && p_cr) t_cr_f = cyc;
        if (run && !p_run) t_run_r = cyc;
        if (!run && p_run) t_run_f = cyc;
        if (wr_v && !p_wr) begin n_wr++; wr_data = wr_d; wr_addr = wr_a; end
        p_pix = pix; p_sd = sd_n; p_pr = pr_n; p_cr = cr_n; p_run = run; p_wr = wr_v;
        // per-clock comparison against the model while no request is in flight
        if (rst_n && !in_op) begin
            checks++;
            if (pix !== m_up || sd_n !== m_up || pr_n !== m_up || cr_n !== m_up ||
                run !== m_up || busy !== 1'b0 || cnt !== 4'(m_cnt)) begin
                errors++;
                $display("FAIL R12 idle outputs actual=%0d%0d%0d%0d%0d cnt=%0d expected up=%0d cnt=%0d",
                         pix, sd_n, pr_n, cr_n, run, cnt, m_up, m_cnt);
            end
        end
    end

    int got_code;

    task automatic do_op(input bit is_start);
        int k;
        clear_ev();
        in_op = 1;
        @(negedge clk);
        if (is_start) start_i = 1'b1; else stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R12 request never completed actual=0 expected=1");
        end
        got_code = code;
        @(negedge clk);
    endtask

    task automatic finish_op(input int exp_cnt, input bit exp_up);
        m_cnt = exp_cnt;
        m_up  = exp_up;
        in_op = 0;
    endtask

    task automatic good_start(input int r, input bit rv, input int exp_code);
        rate = 11'(r); rate_valid = rv;
        do_op(1);
        chk("R4 range code", wr_data, exp_code);
        chk("R4 start ok", got_code, 0);
        finish_op(1, 1);
        do_op(0);
        chk("R12 stop ok", got_code, 0);
        finish_op(0, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_ev();
        in_op = 1;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 pix", pix, 0); chk("R1 shutdown", sd_n, 0); chk("R1 phy rst", pr_n, 0);
        chk("R1 ctrl rst", cr_n, 0); chk("R1 run", run, 0); chk("R1 wr", wr_v, 0);
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 cnt", cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        in_op = 0;

        // R2: no source / no consumer
        src_ok = 0;
        do_op(1);
        chk("R2 code no src", got_code, 1); chk("R2 pix untouched", t_pix_r, -1); chk("R2 cnt", cnt, 0);
        finish_op(0, 0);
        src_ok = 1; sink_ok = 0;
        do_op(1);
        chk("R2 code no sink", got_code, 1); chk("R2 no write", n_wr, 0);
        finish_op(0, 0);
        sink_ok = 1;

        // R3: lane count out of range
        lanes = 0;
        do_op(1);
        chk("R3 zero lanes", got_code, 2); chk("R3 pix untouched", t_pix_r, -1);
        finish_op(0, 0);
        lanes = 5;
        do_op(1);
        chk("R3 too many lanes", got_code, 2);
        finish_op(0, 0);
        lanes = 2;

        // R4: rate at table end
        rate = 11'd1000;
        do_op(1);
        chk("R4 rate error", got_code, 3); chk("R4 no write", n_wr, 0);
        chk("R4 no release", t_sd_r, -1); chk("R4 pix pulsed", (t_pix_r > 0 && t_pix_f > t_pix_r) ? 1 : 0, 1);
        finish_op(0, 0);
        rate = 11'd300;

        // R6/R8/R10: one active lane missing stop state
        lane_stop = 4'b0001; clk_stop = 1; clk_hs = 1;
        do_op(1);
        chk("R6 partial lanes", got_code, 4); chk("R10 run never", t_run_r, -1);
        chk("R8 stop timeout length", t_cr_f - t_cr_r, TMO + 1);
        chk("R10 pix after resets", t_pix_f - t_cr_f, 1);
        finish_op(0, 0);

        // R6: clock-lane stop missing
        lane_stop = 4'b0011; clk_stop = 0;
        do_op(1);
        chk("R6 clock lane stop", got_code, 4);
        finish_op(0, 0);

        // R8/R9: clock never active
        clk_stop = 1; clk_hs = 0;
        do_op(1);
        chk("R8 clock timeout", got_code, 5);
        chk("R8 clock timeout length", t_run_f - t_run_r, TMO + 1);
        chk("R9 resets after run drop", t_cr_f - t_run_f, 1);
        chk("R9 pix last", t_pix_f - t_cr_f, 1);
        finish_op(0, 0);

        // R5/R6/R7: full start, inactive lanes 2,3 low
        clk_hs = 1; lane_stop = 4'b0011;
        do_op(1);
        chk("R7 success", got_code, 0); chk("R5 write count", n_wr, 1);
        chk("R5 write addr", wr_addr, 8'h44); chk("R4 code 300", wr_data, 8'h48);
        chk("R5 lane field", lane_cfg, 1);
        chk("R5 pix before write", (t_pix_r > 0 && t_pix_r < t_sd_r) ? 1 : 0, 1);
        chk("R5 shutdown then phy", t_pr_r - t_sd_r, 1);
        chk("R5 phy then ctrl", t_cr_r - t_pr_r, 1);
        chk("R7 run after ctrl", t_run_r - t_cr_r, 1);
        chk("R11 cnt one", cnt, 1);
        finish_op(1, 1);

        // R11: nested start and stop
        do_op(1);
        chk("R11 inc", cnt, 2); chk("R11 no write", n_wr, 0); chk("R11 no reset edge", t_cr_f, -1);
        finish_op(2, 1);
        do_op(0);
        chk("R11 dec", cnt, 1); chk("R11 still up", run, 1);
        finish_op(1, 1);

        // R12: last stop and stop at zero
        do_op(0);
        chk("R12 cnt zero", cnt, 0); chk("R12 resets after run", t_cr_f - t_run_f, 1);
        chk("R12 pix last", t_pix_f - t_cr_f, 1);
        finish_op(0, 0);
        do_op(0);
        chk("R12 stop at zero code", got_code, 0); chk("R12 stop at zero cnt", cnt, 0);
        finish_op(0, 0);

        // R4: lookup boundaries, all four lanes
        lanes = 4; lane_stop = 4'b1111;
        good_start(849, 0, 8'h14);
        good_start(89, 1, 8'h00);
        good_start(90, 1, 8'h20);
        good_start(849, 1, 8'h14);
        good_start(850, 1, 8'h34);
        good_start(999, 1, 8'h74);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule